// File: doc/BRIEF.md
# DDR SDRAM Command Sequencing Monitor

This block sits beside a DDR SDRAM command bus and samples it on every rising clock edge. It turns the clock-enable pair (the level at the previous edge and at the current one), the four strobes, the address line A10 and the bank address into one decoded command. It keeps a model of each bank: idle, open, or closing on its own after an access with auto-precharge. It also tracks the clock-enable power state and the time since the last precharge. A command that breaks the sequencing rules raises a one-cycle violation flag with an error code. The offending command is then left out of the tracked state, so one mistake does not produce a chain of follow-on errors.

All outputs are registered. The result for the command sampled at an edge appears right after that edge. The burst length, the precharge time and the write recovery time are parameters. The lockout after a read with auto-precharge lasts BL/2+tRP cycles. The lockout after a write with auto-precharge lasts BL/2+1+tWR+tRP cycles. Each bank counts its own window, so traffic to the other banks continues while one bank closes.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: While reset is held, and until the first command after reset, the outputs read `cmd_out`=0, `viol`=0, `viol_code`=0, `bank_open`=0 and `pwr_state`=0.
- R2: With the clock enable high at both edges, the command code is: chip select high gives 0 (deselect). With chip select low, the {RAS#,CAS#,WE#} patterns map as follows: 111 gives 1 (no-op), 011 gives 2 (activate), 110 gives 9 (burst stop) and 001 gives 10 (auto refresh). The code is shown on `cmd_out` one cycle after the sampling edge.
- R3: Pattern 101 is a read and 100 is a write. Each gives code 3 or 5 with A10 low and code 4 or 6 (auto-precharge) with A10 high. An accepted activate opens the addressed bank. A plain read or write leaves it open. An auto-precharge access closes it in `bank_open` in the next cycle.
- R4: Pattern 010 is a precharge. With A10 low it gives code 7 and closes only the addressed bank. With A10 high it gives code 8, ignores the bank address and closes every bank.
- R5: After an accepted read with auto-precharge at cycle n, any activate, read, write or precharge to that bank before cycle n+BL/2+tRP is flagged with code 3 and ignored. The same command at cycle n+BL/2+tRP is accepted.
- R6: After an accepted write with auto-precharge at cycle n, the lockout runs until cycle n+BL/2+1+tWR+tRP and is flagged in the same way (code 3).
- R7: While one bank is locked out, commands to the other banks are judged only by their own bank state.
- R8: A read or write to a bank that is not open gives code 1. An activate to an open bank gives code 2.
- R9: Pattern 000 is a mode register set: code 16 when the bank address bit 0 is low, and 17 (extended) when it is high. If any bank is open or locked, it gives code 4. If fewer than tRP cycles have passed since the last accepted precharge, it gives code 5.
- R10: A refresh with the clock enable going high to low gives code 11 and `pwr_state`=3 (self refresh). A deselect or no-op with the clock enable going high to low gives code 12 and state 1 when every bank is idle, or code 13 and state 2 otherwise. A low-to-high clock enable gives code 14 and state 0. Low at both edges gives code 15.
- R11: Any other command sampled with the clock enable going high to low keeps its own command code, is flagged with code 6, and leaves the power state unchanged.
- R12: A flagged command changes no bank state, lockout or precharge timing. Precharge-all during a lockout gives code 3 and leaves the other open banks open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge samples |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_prev | input | 1 | Clock enable at the previous edge |
| cke_cur | input | 1 | Clock enable at this edge |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr_a10 | input | 1 | Address line A10 (auto-precharge / all-bank select) |
| ba | input | BA_W | Bank address |
| cmd_out | output | 5 | Decoded command code of the last sampled cycle |
| viol | output | 1 | Sequencing violation for the last sampled cycle |
| viol_code | output | 4 | Error code, 0 when no violation |
| bank_open | output | NB | One bit per bank, set while the bank is open |
| pwr_state | output | 2 | 0 run, 1 precharge power-down, 2 active power-down, 3 self refresh |

## Verification
Two kinds of event can fall in the same cycle: the lockout of one bank, and a legal access to another bank. The bench opens two banks, starts an auto-precharge access on one, and drives reads, writes and precharges to both during the window. The lockout window must also line up exactly with a command that arrives in its last blocked cycle and in the first free cycle. A behavioural model keeps the absolute cycle at which each bank unlocks. Each cycle it compares the code, flag, error code, bank vector and power state against the design.

// File: rtl/ddr_mon_pkg.sv
// Shared encodings for the DDR command monitor.
// Assumes: command, error and power codes are visible at the ports as plain vectors.
package ddr_mon_pkg;

    typedef enum logic [4:0] {
        CMD_DESEL    = 5'd0,
        CMD_NOP      = 5'd1,
        CMD_ACT      = 5'd2,
        CMD_RD       = 5'd3,
        CMD_RDA      = 5'd4,
        CMD_WR       = 5'd5,
        CMD_WRA      = 5'd6,
        CMD_PRE      = 5'd7,
        CMD_PREA     = 5'd8,
        CMD_BST      = 5'd9,
        CMD_AREF     = 5'd10,
        CMD_SREF_IN  = 5'd11,
        CMD_PDN_PRE  = 5'd12,
        CMD_PDN_ACT  = 5'd13,
        CMD_CKE_EXIT = 5'd14,
        CMD_CKE_HOLD = 5'd15,
        CMD_MRS      = 5'd16,
        CMD_EMRS     = 5'd17
    } cmd_e;

    typedef enum logic [3:0] {
        ERR_NONE      = 4'd0,
        ERR_RW_CLOSED = 4'd1,
        ERR_ACT_OPEN  = 4'd2,
        ERR_LOCKED    = 4'd3,
        ERR_MRS_OPEN  = 4'd4,
        ERR_MRS_TRP   = 4'd5,
        ERR_CKE_CMD   = 4'd6
    } err_e;

    typedef enum logic [1:0] {
        PWR_RUN    = 2'd0,
        PWR_PD_PRE = 2'd1,
        PWR_PD_ACT = 2'd2,
        PWR_SREF   = 2'd3
    } pwr_e;

endpackage

// File: rtl/ddr_cmd_decode.sv
// Turns one sampled bus cycle into a command code.
// Assumes: all_idle reflects the bank state before this edge; a command other
// than refresh, deselect or no-op on a falling clock enable is marked cke_bad.
module ddr_cmd_decode
    import ddr_mon_pkg::*;
(
    input  logic cke_prev,
    input  logic cke_cur,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic a10,
    input  logic mode_sel,
    input  logic all_idle,
    output cmd_e cmd,
    output logic cke_bad
);

    cmd_e base;

    // Strobe pattern to base command, ignoring the clock enable
    always_comb begin
        base = CMD_DESEL;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  base = CMD_NOP;
                3'b011:  base = CMD_ACT;
                3'b101:  base = a10 ? CMD_RDA : CMD_RD;
                3'b100:  base = a10 ? CMD_WRA : CMD_WR;
                3'b010:  base = a10 ? CMD_PREA : CMD_PRE;
                3'b110:  base = CMD_BST;
                3'b001:  base = CMD_AREF;
                default: base = mode_sel ? CMD_EMRS : CMD_MRS;
            endcase
        end
    end

    // Clock-enable transitions override or qualify the base command
    always_comb begin
        cmd     = base;
        cke_bad = 1'b0;
        if (!cke_prev) begin
            cmd = cke_cur ? CMD_CKE_EXIT : CMD_CKE_HOLD;
        end else if (!cke_cur) begin
            if (base == CMD_AREF)
                cmd = CMD_SREF_IN;
            else if (base == CMD_DESEL || base == CMD_NOP)
                cmd = all_idle ? CMD_PDN_PRE : CMD_PDN_ACT;
            else
                cke_bad = 1'b1;
        end
    end

endmodule

// File: rtl/ddr_bank_track.sv
// State of one bank: open flag and auto-precharge lockout down-counter.
// Assumes: the set, clear and start strobes come only from accepted commands.
module ddr_bank_track #(
    parameter int RD_WIN = 5,
    parameter int WR_WIN = 8,
    parameter int CNT_W  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_open,
    input  logic clr_open,
    input  logic start_rd,
    input  logic start_wr,
    output logic is_open,
    output logic is_locked
);

    localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_WIN - 1);
    localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_WIN - 1);

    logic [CNT_W-1:0] cnt;

    // Open flag and lockout counter; counter saturates at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open <= 1'b0;
            cnt     <= '0;
        end else begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            if (set_open)  is_open <= 1'b1;
            if (clr_open)  is_open <= 1'b0;
            if (start_rd)  cnt <= RD_LOAD;
            if (start_wr)  cnt <= WR_LOAD;
        end
    end

    assign is_locked = (cnt != '0);

endmodule

// File: rtl/ddr_rule_check.sv
// Judges one decoded command against bank, lockout and precharge-age state.
// Assumes: bank_hit is one-hot; open and locked are exclusive per bank.
module ddr_rule_check
    import ddr_mon_pkg::*;
#(
    parameter int NB = 4
) (
    input  cmd_e          cmd,
    input  logic          cke_bad,
    input  logic [NB-1:0] bank_hit,
    input  logic [NB-1:0] open_vec,
    input  logic [NB-1:0] lock_vec,
    input  logic          trp_done,
    output err_e          err
);

    logic bank_cmd, rw_cmd, mode_cmd;

    // Classify the command by which rule families apply
    always_comb begin
        bank_cmd = cmd inside {CMD_ACT, CMD_RD, CMD_RDA, CMD_WR, CMD_WRA, CMD_PRE};
        rw_cmd   = cmd inside {CMD_RD, CMD_RDA, CMD_WR, CMD_WRA};
        mode_cmd = cmd inside {CMD_MRS, CMD_EMRS};
    end

    // Priority chain of sequencing rules
    always_comb begin
        err = ERR_NONE;
        if (cke_bad)
            err = ERR_CKE_CMD;
        else if (bank_cmd && |(bank_hit & lock_vec))
            err = ERR_LOCKED;
        else if (cmd == CMD_PREA && |lock_vec)
            err = ERR_LOCKED;
        else if (rw_cmd && !(|(bank_hit & open_vec)))
            err = ERR_RW_CLOSED;
        else if (cmd == CMD_ACT && |(bank_hit & open_vec))
            err = ERR_ACT_OPEN;
        else if (mode_cmd && (|open_vec || |lock_vec))
            err = ERR_MRS_OPEN;
        else if (mode_cmd && !trp_done)
            err = ERR_MRS_TRP;
    end

endmodule

// File: rtl/ddr_cmd_monitor.sv
// Top of the DDR command sequencing monitor: decode, rule check, per-bank
// tracking, precharge-age counter, power state and registered outputs.
// Assumes: one command per clock; a flagged command updates no tracked state.
module ddr_cmd_monitor
    import ddr_mon_pkg::*;
#(
    parameter int NB  = 4,
    parameter int BL  = 4,
    parameter int TRP = 3,
    parameter int TWR = 2,
    localparam int BA_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cke_prev,
    input  logic            cke_cur,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic            addr_a10,
    input  logic [BA_W-1:0] ba,
    output logic [4:0]      cmd_out,
    output logic            viol,
    output logic [3:0]      viol_code,
    output logic [NB-1:0]   bank_open,
    output logic [1:0]      pwr_state
);

    localparam int RD_WIN = BL / 2 + TRP;
    localparam int WR_WIN = BL / 2 + 1 + TWR + TRP;
    localparam int CNT_W  = $clog2(WR_WIN + 1);
    localparam int TRP_W  = $clog2(TRP + 1);
    localparam logic [TRP_W-1:0] TRP_LOAD = TRP_W'(TRP - 1);

    cmd_e             cmd;
    err_e             err;
    pwr_e             pwr_q;
    logic             cke_bad;
    logic             accept;
    logic [NB-1:0]    bank_hit, open_vec, lock_vec;
    logic [TRP_W-1:0] trp_cnt;

    ddr_cmd_decode u_decode (
        .cke_prev (cke_prev),
        .cke_cur  (cke_cur),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .a10      (addr_a10),
        .mode_sel (ba[0]),
        .all_idle (~|open_vec && ~|lock_vec),
        .cmd      (cmd),
        .cke_bad  (cke_bad)
    );

    ddr_rule_check #(.NB(NB)) u_rules (
        .cmd      (cmd),
        .cke_bad  (cke_bad),
        .bank_hit (bank_hit),
        .open_vec (open_vec),
        .lock_vec (lock_vec),
        .trp_done (trp_cnt == '0),
        .err      (err)
    );

    assign accept = (err == ERR_NONE);

    for (genvar b = 0; b < NB; b++) begin : g_bank
        assign bank_hit[b] = (ba == BA_W'(b));

        ddr_bank_track #(
            .RD_WIN (RD_WIN),
            .WR_WIN (WR_WIN),
            .CNT_W  (CNT_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_open  (accept && cmd == CMD_ACT && bank_hit[b]),
            .clr_open  (accept && (cmd == CMD_PREA ||
                        (bank_hit[b] && cmd inside {CMD_PRE, CMD_RDA, CMD_WRA}))),
            .start_rd  (accept && cmd == CMD_RDA && bank_hit[b]),
            .start_wr  (accept && cmd == CMD_WRA && bank_hit[b]),
            .is_open   (open_vec[b]),
            .is_locked (lock_vec[b])
        );
    end

    // Cycles since the last accepted precharge, saturating at zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            trp_cnt <= '0;
        else if (accept && cmd inside {CMD_PRE, CMD_PREA})
            trp_cnt <= TRP_LOAD;
        else if (trp_cnt != '0)
            trp_cnt <= trp_cnt - 1'b1;
    end

    // Clock-enable power state follows accepted entry and exit commands
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwr_q <= PWR_RUN;
        else if (accept) begin
            unique case (cmd)
                CMD_SREF_IN:  pwr_q <= PWR_SREF;
                CMD_PDN_PRE:  pwr_q <= PWR_PD_PRE;
                CMD_PDN_ACT:  pwr_q <= PWR_PD_ACT;
                CMD_CKE_EXIT: pwr_q <= PWR_RUN;
                default:      pwr_q <= pwr_q;
            endcase
        end
    end

    // Registered report of the sampled cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_out   <= '0;
            viol      <= 1'b0;
            viol_code <= '0;
        end else begin
            cmd_out   <= cmd;
            viol      <= !accept;
            viol_code <= err;
        end
    end

    assign bank_open = open_vec;
    assign pwr_state = pwr_q;

endmodule

// File: rtl/ddr_cmd_monitor_chk.sv
// Property checker for ddr_cmd_monitor, attached by bind below.
// Assumes: reset is asserted at time zero.
module ddr_cmd_monitor_chk
    import ddr_mon_pkg::*;
#(
    parameter int NB   = 4,
    parameter int BA_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cke_prev,
    input logic            cke_cur,
    input logic            cs_n,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic            addr_a10,
    input logic [BA_W-1:0] ba,
    input logic [4:0]      cmd_out,
    input logic            viol,
    input logic [3:0]      viol_code,
    input logic [NB-1:0]   bank_open,
    input logic [1:0]      pwr_state
);

    // R8
    act_on_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_prev && cke_cur && !cs_n && !ras_n && cas_n && we_n && bank_open[ba])
        |=> (viol && viol_code == ERR_ACT_OPEN));

    // R3
    read_open_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_prev && cke_cur && !cs_n && ras_n && !cas_n && we_n && !addr_a10 && bank_open[ba])
        |=> (!viol && bank_open[$past(ba)]));

    // R5
    rda_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_out == CMD_RDA && !viol) |-> !bank_open[$past(ba)]);

    // R9
    mrs_all_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_out inside {CMD_MRS, CMD_EMRS} && !viol) |-> ($past(bank_open) == '0));

    // R10
    sref_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_out == CMD_SREF_IN) |-> (pwr_state == PWR_SREF));

    // R11
    cke_fall_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_prev && !cke_cur && !cs_n && ras_n && !cas_n)
        |=> (viol && viol_code == ERR_CKE_CMD && $stable(pwr_state)));

endmodule

bind ddr_cmd_monitor ddr_cmd_monitor_chk #(.NB(NB), .BA_W(BA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke_prev  (cke_prev),
    .cke_cur   (cke_cur),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .addr_a10  (addr_a10),
    .ba        (ba),
    .cmd_out   (cmd_out),
    .viol      (viol),
    .viol_code (viol_code),
    .bank_open (bank_open),
    .pwr_state (pwr_state)
);

// File: tb/ddr_cmd_monitor_tb.sv
// Bench: behavioural reference (absolute unlock cycles, last-precharge cycle)
// compared with every output after every clock.
module ddr_cmd_monitor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NB     = 4;
    localparam int BL     = 4;
    localparam int TRP    = 3;
    localparam int TWR    = 2;
    localparam int RD_WIN = BL / 2 + TRP;
    localparam int WR_WIN = BL / 2 + 1 + TWR + TRP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke_prev = 1'b1, cke_cur = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic addr_a10 = 1'b0;
    logic [1:0] ba = '0;
    logic [4:0] cmd_out;
    logic viol;
    logic [3:0] viol_code;
    logic [NB-1:0] bank_open;
    logic [1:0] pwr_state;

    int vectors = 0;
    int misses  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    bit m_open[NB];
    int m_unlock[NB];
    int m_last_pre = -1000;
    int m_pwr = 0;

    ddr_cmd_monitor #(.NB(NB), .BL(BL), .TRP(TRP), .TWR(TWR)) u_dut (
        .clk (clk), .rst_n (rst_n), .cke_prev (cke_prev), .cke_cur (cke_cur),
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .addr_a10 (addr_a10), .ba (ba), .cmd_out (cmd_out), .viol (viol),
        .viol_code (viol_code), .bank_open (bank_open), .pwr_state (pwr_state)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic compare(input string tag, input int ecmd, input int eerr,
                           input logic [NB-1:0] ebank, input int epwr);
        logic [16:0] act, exp;
        act = {cmd_out, viol, viol_code, bank_open, pwr_state};
        exp = {5'(ecmd), (eerr != 0), 4'(eerr), ebank, 2'(epwr)};
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s cycle %0d: actual cmd=%0d viol=%0b code=%0d open=%b pwr=%0d expected cmd=%0d viol=%0b code=%0d open=%b pwr=%0d",
                     tag, cyc, cmd_out, viol, viol_code, bank_open, pwr_state,
                     ecmd, eerr != 0, eerr, ebank, epwr);
        end
    endtask

    // Drive one cycle at the falling edge, predict, then check at the next falling edge
    task automatic step(input bit kp, input bit kc, input bit cs, input bit ras,
                        input bit cas, input bit we, input bit a10, input int bank,
                        input string tag);
        int base, ecmd, eerr;
        bit bad, any_open, any_lock, hit_lock;
        logic [NB-1:0] ebank;
        bad = 0; eerr = 0; any_open = 0; any_lock = 0;
        for (int b = 0; b < NB; b++) begin
            any_open |= m_open[b];
            any_lock |= (cyc < m_unlock[b]);
        end
        hit_lock = (cyc < m_unlock[bank]);
        if (cs) base = 0;
        else case ({ras, cas, we})
            3'b111: base = 1;
            3'b011: base = 2;
            3'b101: base = a10 ? 4 : 3;
            3'b100: base = a10 ? 6 : 5;
            3'b010: base = a10 ? 8 : 7;
            3'b110: base = 9;
            3'b001: base = 10;
            default: base = (bank % 2 == 1) ? 17 : 16;
        endcase
        if (!kp) ecmd = kc ? 14 : 15;
        else if (!kc) begin
            if (base == 10) ecmd = 11;
            else if (base <= 1) ecmd = (!any_open && !any_lock) ? 12 : 13;
            else begin ecmd = base; bad = 1; end
        end else ecmd = base;

        if (bad) eerr = 6;
        else if (ecmd inside {2, 3, 4, 5, 6, 7} && hit_lock) eerr = 3;
        else if (ecmd == 8 && any_lock) eerr = 3;
        else if (ecmd inside {3, 4, 5, 6} && !m_open[bank]) eerr = 1;
        else if (ecmd == 2 && m_open[bank]) eerr = 2;
        else if (ecmd inside {16, 17} && (any_open || any_lock)) eerr = 4;
        else if (ecmd inside {16, 17} && (cyc - m_last_pre < TRP)) eerr = 5;

        if (eerr == 0) begin
            case (ecmd)
                2: m_open[bank] = 1;
                4: begin m_open[bank] = 0; m_unlock[bank] = cyc + RD_WIN; end
                6: begin m_open[bank] = 0; m_unlock[bank] = cyc + WR_WIN; end
                7: begin m_open[bank] = 0; m_last_pre = cyc; end
                8: begin for (int b = 0; b < NB; b++) m_open[b] = 0; m_last_pre = cyc; end
                11: m_pwr = 3;
                12: m_pwr = 1;
                13: m_pwr = 2;
                14: m_pwr = 0;
                default: ;
            endcase
        end
        for (int b = 0; b < NB; b++) ebank[b] = m_open[b];

        cke_prev = kp; cke_cur = kc; cs_n = cs; ras_n = ras; cas_n = cas;
        we_n = we; addr_a10 = a10; ba = 2'(bank);
        @(posedge clk);
        @(negedge clk);
        compare(tag, ecmd, eerr, ebank, m_pwr);
        cyc++;
    endtask

    task automatic nop(input string tag);       step(1, 1, 0, 1, 1, 1, 0, 0, tag); endtask
    task automatic act(input int b, input string tag);  step(1, 1, 0, 0, 1, 1, 0, b, tag); endtask
    task automatic rd(input int b, input bit ap, input string tag); step(1, 1, 0, 1, 0, 1, ap, b, tag); endtask
    task automatic wr(input int b, input bit ap, input string tag); step(1, 1, 0, 1, 0, 0, ap, b, tag); endtask
    task automatic pre(input int b, input bit all, input string tag); step(1, 1, 0, 0, 1, 0, all, b, tag); endtask
    task automatic mrs(input int b, input string tag);  step(1, 1, 0, 0, 0, 0, 0, b, tag); endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_unlock[b] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R1", 0, 0, '0, 0);
        rst_n = 1'b1;

        // R2 plain decodes
        step(1, 1, 1, 1, 1, 1, 0, 0, "R2");
        nop("R2");
        step(1, 1, 0, 1, 1, 0, 0, 0, "R2");
        step(1, 1, 0, 0, 0, 1, 0, 0, "R2");
        // R3 open, plain access
        act(0, "R3");
        rd(0, 0, "R3");
        wr(0, 0, "R3");
        // R8 closed access, double activate
        rd(1, 0, "R8");
        wr(2, 1, "R8");
        act(0, "R8");
        act(1, "R7");
        // R5 read lockout window
        rd(0, 1, "R5");
        act(0, "R5");
        rd(1, 0, "R7");
        for (int i = 0; i < RD_WIN - 4; i++) nop("R5");
        act(0, "R5");
        act(0, "R5");
        // R6 write lockout window, R12 flagged commands change nothing
        wr(0, 1, "R6");
        pre(0, 0, "R12");
        pre(3, 1, "R12");
        for (int i = 0; i < WR_WIN - 4; i++) nop("R6");
        act(0, "R6");
        act(0, "R6");
        // R9 mode register rules, R4 precharge variants
        mrs(0, "R9");
        pre(0, 0, "R4");
        pre(2, 1, "R4");
        mrs(0, "R9");
        for (int i = 0; i < TRP - 2; i++) nop("R9");
        mrs(0, "R9");
        mrs(1, "R9");
        // R10 refresh and power states
        step(1, 1, 0, 0, 0, 1, 0, 0, "R10");
        step(1, 0, 0, 0, 0, 1, 0, 0, "R10");
        step(0, 0, 1, 1, 1, 1, 0, 0, "R10");
        step(0, 1, 1, 1, 1, 1, 0, 0, "R10");
        step(1, 0, 0, 1, 1, 1, 0, 0, "R10");
        step(0, 1, 1, 1, 1, 1, 0, 0, "R10");
        act(2, "R3");
        step(1, 0, 1, 1, 1, 1, 0, 0, "R10");
        step(0, 0, 1, 1, 1, 1, 0, 0, "R10");
        step(0, 1, 1, 1, 1, 1, 0, 0, "R10");
        // R11 illegal command on falling clock enable
        step(1, 0, 0, 1, 0, 1, 0, 2, "R11");
        step(1, 1, 1, 1, 1, 1, 0, 0, "R11");
        // R7 concurrent traffic beside a write lockout
        act(3, "R7");
        wr(3, 1, "R7");
        rd(2, 0, "R7");
        wr(2, 0, "R7");
        rd(3, 0, "R7");
        pre(2, 0, "R4");
        repeat (WR_WIN) nop("R7");
        act(3, "R7");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule